// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block keeps the 32-bit status and control word of a floating-point unit. Software may load the word through a write port, and only the bits that are defined as writable are stored. After each arithmetic operation, the arithmetic unit reports five raw IEEE exception indications. The block then rebuilds the per-operation cause field from those indications. It also accumulates them into a sticky flag field. When a cause bit is set whose enable bit is also set, the block asks the core to take a trap.

The block drives two control lines to the datapath, both taken straight from the stored word. One selects truncating rounding. The other selects flushing denormal values to zero. A side input marks approximate reciprocal-square-root results. Such a result must always report inexact unless the unit has already reported some other condition.

Trap signalling is handled by a two-state machine. `TRAP_IDLE` is the quiet state. The transition IDLE→FIRE is taken when an accepted operation produces an enabled cause. FIRE→FIRE is taken when the next accepted operation also traps. FIRE→IDLE is taken on any other cycle. While the machine is in `TRAP_FIRE`, the request output is high and the event code is driven.

Top module: `fpu_status_reg`

Field layout of the stored word:
- Bits [1:0] hold the rounding mode. The value 01 means truncate.
- Bits [6:2] hold the sticky flags: I=2, U=3, O=4, Z=5, V=6.
- Bits [11:7] hold the enables in the same order: I=7 up to V=11.
- Bits [16:12] hold the causes: I=12 up to V=16.
- Bit 18 is the denormal flush control.
- Bits 17 and 31:19 always read zero.

The `op_flags` input is ordered {V,Z,O,U,I}, with I at bit 0.

## Requirements
- R1: After reset the word reads 0x00040001, `rnd_trunc` and `flush_dn` are 1, and `exc_req` is 0.
- R2: A write stores `wr_data & 0x0005FFFF` in the following cycle.
- R3: `rnd_trunc` is 1 exactly when bits [1:0] equal 01. The encodings 00, 10 and 11 give 0.
- R4: `flush_dn` always equals bit 18 of the word.
- R5: An accepted operation clears bits [16:12] and then loads them with the effective flags, with I at bit 12 up to V at bit 16. All other fields except the flags are unchanged.
- R6: An accepted operation ORs the effective flags into bits [6:2], with I at bit 2 up to V at bit 6. An operation never clears a flag bit.
- R7: If the new cause field ANDed with the enables [11:7] is nonzero, `exc_req` is high for exactly one cycle, the cycle after the operation strobe, with `exc_code` = 0x120. Otherwise `exc_req` is 0 and `exc_code` is 0.
- R8: When `op_approx` is set and `op_flags` is zero, the effective flags are I only (00001). When `op_approx` is set and any flag is reported, the reported flags are used unchanged.
- R9: A write and an operation strobe in the same cycle store only the write. The operation has no effect and raises no request.
- R10: With no write and no operation the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| op_valid | input | 1 | Operation-complete strobe |
| op_flags | input | 5 | Raw exception flags {V,Z,O,U,I} |
| op_approx | input | 1 | Operation was an approximate reciprocal square root |
| reg_q | output | 32 | Current register value |
| rnd_trunc | output | 1 | Round-toward-zero select |
| flush_dn | output | 1 | Flush-denormal-to-zero select |
| exc_req | output | 1 | Exception request pulse |
| exc_code | output | 12 | Event code, 0x120 during a request |

## Verification
The bench targets several corner cases.
- A write of all ones: a wrong mask would leave bit 17 or the upper bits set.
- An operation after a write that filled the cause field: a design that merges causes instead of clearing them would keep stale cause bits.
- Approximate operations with zero flags and with overflow reported: a design that always forces inexact, or never forces it, would show a wrong I cause in one of the two.
- A write colliding with a trapping operation: a design that lets the operation through would pulse `exc_req` or change the flags.
- Back-to-back trapping operations: a state machine that drops to idle between them would lose the second pulse.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int REG_W     = 32;
    localparam int FLAG_N    = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EN_LSB    = FLAG_LSB + FLAG_N;
    localparam int CAUSE_LSB = EN_LSB + FLAG_N;
    localparam int DN_BIT    = 18;
    localparam int EVT_W     = 12;

    localparam logic [REG_W-1:0] WR_MASK_DEF   = 32'h0005_FFFF;
    localparam logic [REG_W-1:0] RESET_VAL_DEF = 32'h0004_0001;
    localparam logic [RM_W-1:0]  RM_TRUNC      = 2'b01;
    localparam logic [EVT_W-1:0] EVT_CODE_DEF  = 12'h120;
    localparam logic [FLAG_N-1:0] FLAG_INEXACT = 5'b00001;

    typedef enum logic {
        TRAP_IDLE = 1'b0,
        TRAP_FIRE = 1'b1
    } trap_state_e;

    typedef struct packed {
        logic v;
        logic z;
        logic o;
        logic u;
        logic i;
    } ieee_flags_t;
endpackage

// File: rtl/fpsr_flag_merge.sv
module fpsr_flag_merge
    import fpsr_pkg::*;
(
    input  ieee_flags_t raw_flags,
    input  logic        approx,
    output ieee_flags_t eff_flags
);
    logic none_reported;

    always_comb begin
        none_reported = (raw_flags == '0);
        eff_flags     = raw_flags;
        if (approx && none_reported) begin
            eff_flags   = '0;
            eff_flags.i = 1'b1;
        end
    end
endmodule

// File: rtl/fpsr_next_calc.sv
module fpsr_next_calc
    import fpsr_pkg::*;
#(
    parameter logic [REG_W-1:0] WR_MASK = WR_MASK_DEF
) (
    input  logic [REG_W-1:0] cur,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             op_valid,
    input  ieee_flags_t      eff_flags,
    output logic [REG_W-1:0] nxt,
    output logic             trap_hit
);
    logic [FLAG_N-1:0] fvec;
    logic [FLAG_N-1:0] enables;
    logic [FLAG_N-1:0] new_cause;

    always_comb begin
        fvec      = eff_flags;
        enables   = cur[EN_LSB +: FLAG_N];
        new_cause = '0;
        nxt       = cur;
        trap_hit  = 1'b0;
        unique case ({wr_en, op_valid})
            2'b10, 2'b11: begin
                nxt = wr_data & WR_MASK;
            end
            2'b01: begin
                for (int k = 0; k < FLAG_N; k++) begin
                    new_cause[k]            = fvec[k];
                    nxt[CAUSE_LSB + k]      = fvec[k];
                    nxt[FLAG_LSB + k]       = cur[FLAG_LSB + k] | fvec[k];
                end
                trap_hit = |(new_cause & enables);
            end
            default: begin
                nxt = cur;
            end
        endcase
    end
endmodule

// File: rtl/fpsr_ctrl_decode.sv
module fpsr_ctrl_decode
    import fpsr_pkg::*;
(
    input  logic [REG_W-1:0] word,
    output logic             rnd_trunc,
    output logic             flush_dn
);
    always_comb begin
        rnd_trunc = (word[RM_LSB +: RM_W] == RM_TRUNC);
        flush_dn  = word[DN_BIT];
    end
endmodule

// File: rtl/fpsr_trap_fsm.sv
module fpsr_trap_fsm
    import fpsr_pkg::*;
#(
    parameter logic [EVT_W-1:0] EVT_CODE = EVT_CODE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_hit,
    output logic             exc_req,
    output logic [EVT_W-1:0] exc_code
);
    trap_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRAP_IDLE: state_d = trap_hit ? TRAP_FIRE : TRAP_IDLE;
            TRAP_FIRE: state_d = trap_hit ? TRAP_FIRE : TRAP_IDLE;
            default:   state_d = TRAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        exc_req  = 1'b0;
        exc_code = '0;
        unique case (state_q)
            TRAP_FIRE: begin
                exc_req  = 1'b1;
                exc_code = EVT_CODE;
            end
            default: begin
                exc_req  = 1'b0;
                exc_code = '0;
            end
        endcase
    end
endmodule

// File: rtl/fpu_status_reg.sv
module fpu_status_reg
    import fpsr_pkg::*;
#(
    parameter logic [REG_W-1:0] WR_MASK   = WR_MASK_DEF,
    parameter logic [REG_W-1:0] RESET_VAL = RESET_VAL_DEF,
    parameter logic [EVT_W-1:0] EVT_CODE  = EVT_CODE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             op_valid,
    input  logic [4:0]       op_flags,
    input  logic             op_approx,
    output logic [31:0]      reg_q,
    output logic             rnd_trunc,
    output logic             flush_dn,
    output logic             exc_req,
    output logic [11:0]      exc_code
);
    ieee_flags_t      eff_flags;
    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] word_d;
    logic             trap_hit;

    fpsr_flag_merge u_merge (
        .raw_flags (ieee_flags_t'(op_flags)),
        .approx    (op_approx),
        .eff_flags (eff_flags)
    );

    fpsr_next_calc #(.WR_MASK(WR_MASK)) u_next (
        .cur       (word_q),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .op_valid  (op_valid),
        .eff_flags (eff_flags),
        .nxt       (word_d),
        .trap_hit  (trap_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= RESET_VAL;
        else        word_q <= word_d;
    end

    fpsr_ctrl_decode u_dec (
        .word      (word_q),
        .rnd_trunc (rnd_trunc),
        .flush_dn  (flush_dn)
    );

    fpsr_trap_fsm #(.EVT_CODE(EVT_CODE)) u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_hit (trap_hit),
        .exc_req  (exc_req),
        .exc_code (exc_code)
    );

    assign reg_q = word_q;
endmodule

// File: rtl/fpu_status_reg_chk.sv
module fpu_status_reg_chk
    import fpsr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        op_valid,
    input logic [31:0] reg_q,
    input logic        rnd_trunc,
    input logic        flush_dn,
    input logic        exc_req,
    input logic [11:0] exc_code
);
    p_write_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> reg_q == ($past(wr_data) & WR_MASK_DEF));

    p_trunc_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_trunc == (reg_q[1:0] == 2'b01));

    p_flush_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dn == reg_q[18]);

    p_cause_in_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en) |=> ((reg_q[16:12] & ~reg_q[6:2]) == 5'b0));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en) |=> (($past(reg_q[6:2]) & ~reg_q[6:2]) == 5'b0));

    p_trap_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en) |=> exc_req == |(reg_q[16:12] & reg_q[11:7]));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !exc_req);

    p_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_code == (exc_req ? 12'h120 : 12'h000));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !exc_req);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !op_valid) |=> $stable(reg_q));
endmodule

bind fpu_status_reg fpu_status_reg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .op_valid  (op_valid),
    .reg_q     (reg_q),
    .rnd_trunc (rnd_trunc),
    .flush_dn  (flush_dn),
    .exc_req   (exc_req),
    .exc_code  (exc_code)
);

// File: tb/test_fpu_status_reg.sv
module test_fpu_status_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        op_approx = 1'b0;
    logic [31:0] reg_q;
    logic        rnd_trunc, flush_dn, exc_req;
    logic [11:0] exc_code;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_reg;
    logic        exp_req;

    always #5 clk = ~clk;

    fpu_status_reg i_fpu_status_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_valid(op_valid), .op_flags(op_flags), .op_approx(op_approx),
        .reg_q(reg_q), .rnd_trunc(rnd_trunc), .flush_dn(flush_dn),
        .exc_req(exc_req), .exc_code(exc_code)
    );

    function automatic logic [4:0] eff(input logic [4:0] f, input logic ap);
        return (ap && f == 5'b0) ? 5'b00001 : f;
    endfunction

    function automatic logic [31:0] after_op(input logic [31:0] cur, input logic [4:0] m);
        logic [31:0] r = cur;
        r[16:12] = m;
        r[6:2]   = cur[6:2] | m;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic w, input logic [31:0] d,
                        input logic op, input logic [4:0] f, input logic ap);
        logic [31:0] nreg;
        logic        ntrap;
        logic [4:0]  m;
        @(negedge clk);
        wr_en = w; wr_data = d; op_valid = op; op_flags = f; op_approx = ap;
        m = eff(f, ap);
        nreg = exp_reg; ntrap = 1'b0;
        if (w) nreg = d & 32'h0005_FFFF;
        else if (op) begin
            nreg  = after_op(exp_reg, m);
            ntrap = |(m & exp_reg[11:7]);
        end
        @(posedge clk); #1;
        exp_reg = nreg; exp_req = ntrap;
        chk(tag, reg_q, exp_reg);
        chk("R7 req", {31'b0, exc_req}, {31'b0, exp_req});
        chk("R7 code", {20'b0, exc_code}, exp_req ? 32'h120 : 32'h0);
        chk("R3 trunc", {31'b0, rnd_trunc}, {31'b0, exp_reg[1:0] == 2'b01});
        chk("R4 flush", {31'b0, flush_dn}, {31'b0, exp_reg[18]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        exp_reg = 32'h0004_0001; exp_req = 1'b0;
        #12; rst_n = 1'b1; #1;
        // R1 reset state
        chk("R1 reg", reg_q, 32'h0004_0001);
        chk("R1 trunc", {31'b0, rnd_trunc}, 32'd1);
        chk("R1 flush", {31'b0, flush_dn}, 32'd1);
        chk("R1 req", {31'b0, exc_req}, 32'd0);
        // R2 mask
        step("R2 all ones", 1, 32'hFFFF_FFFF, 0, 0, 0);
        step("R2 zero", 1, 32'h0, 0, 0, 0);
        // R3 each rounding encoding, R4 with bit 18 toggling
        for (int e = 0; e < 4; e++) begin
            step("R3 rm", 1, {13'b0, e[0], 16'b0, e[1:0]}, 0, 0, 0);
        end
        // R5 cause cleared then reloaded
        step("R5 fill", 1, 32'h0001_F000, 0, 0, 0);
        step("R5 reload", 0, 0, 1, 5'b00100, 0);
        // R6 sticky
        step("R6 second", 0, 0, 1, 5'b00010, 0);
        step("R6 none", 0, 0, 1, 5'b00000, 0);
        // R8 approximate
        step("R8 force I", 0, 0, 1, 5'b00000, 1);
        step("R8 keep O", 0, 0, 1, 5'b00100, 1);
        // R7 trap: enable Z and V, back-to-back
        step("R7 en", 1, 32'h0000_0C00, 0, 0, 0);
        step("R7 trap z", 0, 0, 1, 5'b01000, 0);
        step("R7 trap v", 0, 0, 1, 5'b10000, 0);
        step("R7 no trap", 0, 0, 1, 5'b00001, 0);
        // R9 collision
        step("R9 collide", 1, 32'h0000_0F80, 1, 5'b11111, 0);
        // R10 hold
        step("R10 hold", 0, 0, 0, 5'b11111, 1);
        step("R10 hold2", 0, 0, 0, 0, 0);
        // random mix
        for (int it = 0; it < 400; it++) begin
            logic w, op, ap;
            w  = ($urandom % 8) == 0;
            op = ($urandom % 2) == 0;
            ap = ($urandom % 4) == 0;
            step(w ? "R2 rnd" : (op ? "R5 R6 rnd" : "R10 rnd"), w, $urandom, op,
                 (($urandom % 3) == 0) ? 5'b0 : 5'($urandom), ap);
        end
        step("R10 idle", 0, 0, 0, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule